// File: doc/BRIEF.md
# Serial Transport-Overhead Output Port

This block sends the complete transport overhead of a 12-channel STS-12 frame out as a single-bit stream, one bit per overhead clock. The overhead of one frame is 9 rows by 3 columns for each of the 12 STS-1 channels, which is 324 bytes or 2592 bits. The block reads the bytes in frame order from a buffer held upstream. The buffer has an asynchronous read port. The block drives the byte address and takes the byte back in the same cycle. Address k holds row r, column c of channel s, where k = 36r + 12c + s. The effect is that the channels interleave inside each column, and the rows follow one after the other.

Each byte goes out most significant bit first. The first bit of a frame is the top bit of byte 0, which is the first framing byte. That bit is not sent as it stands. It is replaced by an even-parity bit computed over all 2592 original bits of the previous frame. A sync output marks that bit so that downstream logic can find the frame boundary. After a start pulse, frames follow each other without a gap. The port only stops at reset.

Top module: `toh_serial_port`

## Requirements
- R1: After reset, `ser_o` and `sync_o` stay 0 until a `start_i` pulse has been taken.
- R2: `start_i` is sampled at a clock edge while the port is idle. One cycle after that edge, `byte_addr_o` is 0 and the frame's first bit is being read. `sync_o` is high during the cycle after that, and only for that single cycle.
- R3: Within each frame, `byte_addr_o` counts up from 0 to 323 and holds each value for 8 cycles. Bit j of the frame (j > 0) is bit 7 − (j mod 8) of byte j/8. It appears on `ser_o` one cycle after it was read.
- R4: The bit sent while `sync_o` is high is the XOR of all 2592 bits of the previous frame as they were read. This includes the true top bit of byte 0, not the parity bit that was sent in its place. The result is even parity.
- R5: The first frame after reset carries a parity bit of 0.
- R6: A `start_i` pulse while frames are running has no effect on the address sequence or on frame timing.
- R7: Frames follow each other with no idle cycle. `sync_o` pulses exactly every 2592 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts the frame sequence when idle |
| byte_i | input | 8 | Overhead byte read from the buffer at `byte_addr_o` |
| byte_addr_o | output | 9 | Buffer address of the byte being serialized |
| ser_o | output | 1 | Serial overhead data |
| sync_o | output | 1 | High on the parity bit that starts each frame |

## Verification
The bench drives a directed frame that has only the top bit of byte 0 set. A design that folded the sent parity bit into the sum, instead of the true bit, would send 0 on the next frame instead of 1. An all-ones frame checks that an even count of ones gives 0. A reset in the middle of a frame followed by a new start checks that stale parity is not carried over, and a design that kept it would send a nonzero first parity bit. A start pulse in the middle of a frame would shift every later bit and address in a design that restarted on it.

// File: rtl/toh_ser_pkg.sv
package toh_ser_pkg;
  // total overhead bytes in one frame
  function automatic int frame_bytes(input int n_sts, input int n_rows, input int n_cols);
    return n_sts * n_rows * n_cols;
  endfunction

  // select a bit of a byte, msb first for sel = 0
  function automatic logic msb_first_bit(input logic [7:0] b, input logic [2:0] sel);
    return b[3'd7 - sel];
  endfunction

  // one accumulation step of even parity
  function automatic logic par_step(input logic acc, input logic din, input logic restart);
    return restart ? din : (acc ^ din);
  endfunction
endpackage

// File: rtl/toh_pos_seq.sv
module toh_pos_seq #(
  parameter int BYTES  = 324,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              run_o,
  output logic              first_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        sel_o
);
  localparam int POS_W = ADDR_W + 3;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTES * 8 - 1);

  logic             run_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else if (!run_q) begin
      run_q <= start_i;
      pos_q <= '0;
    end else begin
      pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign first_o = run_q && (pos_q == '0);
  assign last_o  = run_q && (pos_q == LAST_POS);
  assign addr_o  = pos_q[POS_W-1:3];
  assign sel_o   = pos_q[2:0];

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (run_q && pos_q == '0));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + 1'b1));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pos_q[2:0] != 3'd7) |=> $stable(addr_o));
endmodule

// File: rtl/toh_par_acc.sv
module toh_par_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic first_i,
  input  logic last_i,
  input  logic din_i,
  output logic par_o
);
  import toh_ser_pkg::*;

  logic acc_q;
  logic par_q;
  logic acc_nx;

  assign acc_nx = par_step(acc_q, din_i, first_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (en_i) begin
      acc_q <= acc_nx;
      if (last_i) par_q <= acc_nx;
    end
  end

  assign par_o = par_q;

  p_par_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && last_i) |=> $stable(par_q));
endmodule

// File: rtl/toh_serial_port.sv
module toh_serial_port #(
  parameter int N_STS  = 12,
  parameter int N_ROWS = 9,
  parameter int N_COLS = 3,
  parameter int ADDR_W = $clog2(N_STS * N_ROWS * N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              ser_o,
  output logic              sync_o
);
  import toh_ser_pkg::*;

  localparam int BYTES = frame_bytes(N_STS, N_ROWS, N_COLS);

  logic       run;
  logic       frm_first;
  logic       frm_last;
  logic [2:0] bit_sel;
  logic       cur_bit;
  logic       par_prev;
  logic       ser_q;
  logic       sync_q;

  toh_pos_seq #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .run_o  (run),
    .first_o(frm_first),
    .last_o (frm_last),
    .addr_o (byte_addr_o),
    .sel_o  (bit_sel)
  );

  assign cur_bit = msb_first_bit(byte_i, bit_sel);

  toh_par_acc u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run),
    .first_i(frm_first),
    .last_i (frm_last),
    .din_i  (cur_bit),
    .par_o  (par_prev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= frm_first;
      ser_q  <= run ? (frm_first ? par_prev : cur_bit) : 1'b0;
    end
  end

  assign ser_o  = ser_q;
  assign sync_o = sync_q;

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (!ser_o && !sync_o));
  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
endmodule

// File: tb/toh_serial_port_tb.sv
module toh_serial_port_tb;
  localparam int BYTES = 324;
  localparam int FBITS = BYTES * 8;
  localparam int NFR   = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] byte_i;
  logic [8:0] byte_addr_o;
  logic       ser_o;
  logic       sync_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int wd = 0;
  logic [7:0] mem [NFR][BYTES];
  logic       fpar [NFR];

  always #5 clk = ~clk;

  toh_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
    .byte_addr_o(byte_addr_o), .ser_o(ser_o), .sync_o(sync_o)
  );

  always_comb byte_i = mem[(cyc / FBITS) % NFR][byte_addr_o];

  function automatic logic frame_parity(input int f);
    logic p = 1'b0;
    for (int a = 0; a < BYTES; a++) p ^= ^mem[f][a];
    return p;
  endfunction

  function automatic logic exp_bit(input int q);
    int f = q / FBITS;
    int p = q % FBITS;
    if (p == 0) return (f == 0) ? 1'b0 : fpar[(f - 1) % NFR];
    return mem[f % NFR][p / 8][7 - (p % 8)];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic run_frames(input int ncyc, input bit poke_start);
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    @(negedge clk) start_i = 1'b0;
    cyc = 0;
    // R3: address 0 in the cycle right after start is taken
    check("R3", int'(byte_addr_o), 0);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      // R2 R7: sync exactly on the first bit of each frame
      check("R2", int'(sync_o), ((cyc - 1) % FBITS == 0) ? 1 : 0);
      // R3 R4 R5: data bits and parity bits
      check(((cyc - 1) % FBITS == 0) ? "R4" : "R3", int'(ser_o), int'(exp_bit(cyc - 1)));
      check("R3", int'(byte_addr_o), (cyc % FBITS) / 8);
      start_i = (poke_start && cyc == 1000) ? 1'b1 : 1'b0; // R6
    end
  endtask

  initial begin
    void'($urandom(32'd4021));
    for (int f = 0; f < NFR; f++)
      for (int a = 0; a < BYTES; a++) begin
        case (f)
          1: mem[f][a] = 8'hFF;
          2: mem[f][a] = (a == 0) ? 8'h80 : 8'h00;
          default: mem[f][a] = 8'($urandom);
        endcase
      end
    for (int f = 0; f < NFR; f++) fpar[f] = frame_parity(f);
    check("R4", int'(fpar[1]), 0);
    check("R4", int'(fpar[2]), 1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R1", int'(ser_o), 0);
      check("R1", int'(sync_o), 0);
    end

    run_frames(NFR * FBITS + 100, 1'b1);

    // mid-frame reset, then a fresh start: stale parity must not survive
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1", int'(ser_o), 0);
      check("R1", int'(sync_o), 0);
    end
    // R5: first frame parity 0, then parity of frame 0
    run_frames(2 * FBITS + 10, 1'b0);
    finish_run();
  end
endmodule